// File: doc/BRIEF.md
# SPI flash block-erase sequencer

This block sits on the host side of a single-bit SPI link (mode 0: SCLK idles low, data is launched on the falling edge and captured on the rising edge) to an external serial NOR flash. It erases one 64 KB block per request. A one-cycle `req` pulse carries a 24-bit byte address. Only the top eight address bits, which give the block index, are used. The sequencer then runs four kinds of transfer in a fixed order, each framed by its own chip-select low period:

- a write-enable command (06h, 8 clocks);
- a status read (05h plus 8 capture clocks), which confirms that the write-enable latch is set;
- the erase command (D8h) with the block address, 32 clocks in all;
- repeated status reads until the busy flag drops.

The outcome is reported with a one-cycle `done` pulse and a result code. The code is valid in the cycle that `done` is high.

Several settings are inputs: the SCLK half-period, the minimum chip-select high time between commands and the limit on status polls. A protection input stands for the flash's sector-protect setting. While it is set, a request aimed at the lowest or highest block of the array is refused without touching the bus.

Top module: `spi_blkerase_seq`

## Requirements
- R1: While `rst_n` is low and after it rises, `cs_n` is 1, `sclk` is 0, `mosi` is 0, and `busy` and `done` are 0.
- R2: An accepted request produces these frames in order, each sent most-significant bit first in mode 0:
  - 06h over 8 clocks;
  - 05h over 16 clocks;
  - D8h followed by a 24-bit address over 32 clocks;
  - one or more further 05h frames of 16 clocks.
- R3: In the erase frame, address bits 23..16 equal `addr[23:16]` and bits 15..0 are zero.
- R4: Every frame has exactly 8, 16 or 32 SCLK rising edges while `cs_n` is low. `cs_n` rises only after the last falling edge, and `sclk` is 0 whenever `cs_n` is 1.
- R5: Every SCLK half-period, including the time from the `cs_n` fall to the first rising edge, lasts `clk_div`+1 system clocks.
- R6: Between consecutive frames `cs_n` stays high for at least `cs_gap` system clocks, and for at least 1.
- R7: If status bit 1 (the write-enable latch) is 0 in the read after write-enable, no erase frame is sent and `done` comes with `result` = 2.
- R8: Status reads repeat while status bit 0 (busy) is 1. When bit 0 is 0 and bit 1 is 0, `done` comes with `result` = 0.
- R9: When `poll_limit` status reads in a row have returned busy, polling stops with `result` = 3. No further frame follows.
- R10: If bit 0 is 0 but bit 1 is still 1 when polling ends, `done` comes with `result` = 4.
- R11: When `sec_protect` is 1 and `addr[23:16]` is 0 or NUM_BLOCKS-1 (31 by default), no frame is sent and `done` comes with `result` = 1. Any other block, or `sec_protect` = 0, proceeds normally.
- R12: `busy` is 1 from the cycle after an accepted `req` until `done`. `done` is high for exactly one cycle. A `req` that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start pulse, accepted when not busy |
| addr | input | 24 | Byte address; bits 23..16 select the block |
| sec_protect | input | 1 | Mirror of the flash's sector-protect setting |
| clk_div | input | 8 | SCLK half-period minus one, in system clocks |
| cs_gap | input | 8 | Minimum chip-select high time between frames |
| poll_limit | input | 16 | Maximum number of busy status reads |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 protected, 2 latch not set, 3 timeout, 4 latch stuck |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data toward the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The bench attaches a behavioural flash that decodes each frame at the `cs_n` rise. The flash executes an erase only if the write-enable latch is set and the frame had exactly 32 clocks, so a sequencer that adds one clock or drops the write-enable leaves the erase count at zero. The flash can be set to ignore write-enable, to stay busy for a chosen number of reads, or to leave the latch set. These settings drive the latch-fail, timeout and latch-stuck paths. An off-by-one in the poll counter would show up as one poll too many or too few, and a wrong status bit would report the wrong result code.

The protect guard is tried on both edge blocks and on a middle block with protection set, and on the top block with protection clear. A guard with an inverted or missing comparison would either send frames or refuse a legal erase. The bench also measures the SCLK half-periods and the chip-select gaps. A second request is pulsed in the middle of an erase to catch an address that is re-latched while busy.

// File: rtl/blkerase_pkg.sv
// Shared constants and types for the block-erase sequencer.
// Assumes: single-bit SPI flash that accepts the opcodes below.
package blkerase_pkg;
    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_RDSR   = 8'h05;
    localparam logic [7:0] OPC_BERASE = 8'hD8;

    // Outcome reported with the done pulse
    typedef enum logic [2:0] {
        RES_OK        = 3'd0,
        RES_PROT      = 3'd1,
        RES_WEL_FAIL  = 3'd2,
        RES_TIMEOUT   = 3'd3,
        RES_WEL_STUCK = 3'd4
    } be_result_e;

    // Which frame of the sequence is current
    typedef enum logic [1:0] {
        STEP_WREN,
        STEP_WELCHK,
        STEP_ERASE,
        STEP_POLL
    } be_step_e;
endpackage

// File: rtl/be_sclk_tick.sv
// Half-period tick generator for SCLK.
// Emits one tick every div+1 clocks while en is high; restarts when en drops.
// Assumes: div is held stable while en is high.
module be_sclk_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    // Count system clocks within one SCLK half-period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5
    tick_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $stable(div)) |-> (cnt <= div));
endmodule

// File: rtl/be_spi_shift.sv
// Mode-0 SPI frame engine.
// One start launches a frame of nbits clocks: cs_n falls, tx goes out MSB first
// (MSB aligned in tx), MISO is captured on each rising SCLK edge, and cs_n rises
// on the final falling edge with no further clock. rx keeps the last 8 bits.
// Assumes: start is only honoured while no frame is active; nbits >= 1.
module be_spi_shift #(
    parameter int FRAME_W = 32,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   nbits,
    input  logic [FRAME_W-1:0] tx,
    input  logic               tick,
    input  logic               miso,
    output logic               active,
    output logic               done,
    output logic [7:0]         rx,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi
);
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   left;

    // Frame framing, bit shifting and MISO capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            done   <= 1'b0;
            rx     <= '0;
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
            mosi   <= 1'b0;
            sh     <= '0;
            left   <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    cs_n   <= 1'b0;
                    mosi   <= tx[FRAME_W-1];
                    sh     <= {tx[FRAME_W-2:0], 1'b0};
                    left   <= nbits;
                end
            end else if (tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (left == CNT_W'(1)) begin
                        active <= 1'b0;
                        cs_n   <= 1'b1;
                        done   <= 1'b1;
                        mosi   <= 1'b0;
                    end else begin
                        left <= left - 1'b1;
                        mosi <= sh[FRAME_W-1];
                        sh   <= {sh[FRAME_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R4
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));
endmodule

// File: rtl/be_seq_ctrl.sv
// Block-erase command sequencer.
// Runs write-enable, latch check, erase and busy polling as separate frames,
// enforces the chip-select gap, applies the edge-block protection guard and
// reports the outcome with a one-cycle done pulse.
// Assumes: configuration inputs are stable while busy.
module be_seq_ctrl
    import blkerase_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int BLK_LSB    = 16,
    parameter int NUM_BLOCKS = 32,
    parameter int GAP_W      = 8,
    parameter int POLL_W     = 16,
    parameter int FRAME_W    = 32,
    parameter int CNT_W      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               sec_protect,
    input  logic [GAP_W-1:0]   cs_gap,
    input  logic [POLL_W-1:0]  poll_limit,
    input  logic               xfer_done,
    input  logic [7:0]         rx_byte,
    output logic               xfer_start,
    output logic [CNT_W-1:0]   xfer_nbits,
    output logic [FRAME_W-1:0] xfer_tx,
    output logic               busy,
    output logic               done,
    output logic [2:0]         result
);
    localparam int BLK_W = ADDR_W - BLK_LSB;
    localparam logic [BLK_W-1:0] TOP_BLK = BLK_W'(NUM_BLOCKS - 1);

    typedef enum logic [1:0] {S_IDLE, S_REFUSE, S_XFER, S_GAP} state_e;

    state_e             state;
    be_step_e           step;
    be_result_e         res_q;
    logic               launched;
    logic [BLK_W-1:0]   blk_q;
    logic [BLK_W-1:0]   blk_in;
    logic [GAP_W-1:0]   gap_cnt;
    logic [GAP_W-1:0]   gap_len;
    logic [POLL_W-1:0]  poll_cnt;
    logic               guard_hit;
    logic               gap_over;
    logic               poll_exhausted;
    logic               st_busy;
    logic               st_wel;
    logic               addr_low_unused;
    logic               rx_high_unused;

    assign blk_in          = addr[ADDR_W-1:BLK_LSB];
    assign addr_low_unused = ^addr[BLK_LSB-1:0];
    assign rx_high_unused  = ^rx_byte[7:2];
    assign st_busy         = rx_byte[0];
    assign st_wel          = rx_byte[1];

    // Edge-block protection guard on the incoming address
    assign guard_hit = sec_protect && ((blk_in == '0) || (blk_in == TOP_BLK));

    // Gap length with a floor of one clock; gap and poll limit comparisons
    always_comb begin
        gap_len        = (cs_gap == '0) ? GAP_W'(1) : cs_gap;
        gap_over       = ({1'b0, gap_cnt} + 1'b1) >= {1'b0, gap_len};
        poll_exhausted = ({1'b0, poll_cnt} + 1'b1) >= {1'b0, poll_limit};
    end

    // Frame contents for the current step
    always_comb begin
        case (step)
            STEP_WREN: begin
                xfer_tx    = {OPC_WREN, {ADDR_W{1'b0}}};
                xfer_nbits = CNT_W'(8);
            end
            STEP_ERASE: begin
                xfer_tx    = {OPC_BERASE, blk_q, {BLK_LSB{1'b0}}};
                xfer_nbits = CNT_W'(FRAME_W);
            end
            default: begin
                xfer_tx    = {OPC_RDSR, {ADDR_W{1'b0}}};
                xfer_nbits = CNT_W'(16);
            end
        endcase
    end

    assign xfer_start = (state == S_XFER) && !launched;
    assign busy       = (state != S_IDLE);
    assign result     = res_q;

    // Sequence state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            step     <= STEP_WREN;
            res_q    <= RES_OK;
            launched <= 1'b0;
            blk_q    <= '0;
            gap_cnt  <= '0;
            poll_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req) begin
                        blk_q <= blk_in;
                        if (guard_hit) begin
                            state <= S_REFUSE;
                        end else begin
                            step     <= STEP_WREN;
                            launched <= 1'b0;
                            state    <= S_XFER;
                        end
                    end
                end
                S_REFUSE: begin
                    done  <= 1'b1;
                    res_q <= RES_PROT;
                    state <= S_IDLE;
                end
                S_XFER: begin
                    launched <= 1'b1;
                    if (xfer_done) begin
                        launched <= 1'b0;
                        gap_cnt  <= '0;
                        case (step)
                            STEP_WREN: begin
                                step  <= STEP_WELCHK;
                                state <= S_GAP;
                            end
                            STEP_WELCHK: begin
                                if (st_wel) begin
                                    step  <= STEP_ERASE;
                                    state <= S_GAP;
                                end else begin
                                    done  <= 1'b1;
                                    res_q <= RES_WEL_FAIL;
                                    state <= S_IDLE;
                                end
                            end
                            STEP_ERASE: begin
                                step     <= STEP_POLL;
                                poll_cnt <= '0;
                                state    <= S_GAP;
                            end
                            default: begin
                                if (st_busy) begin
                                    if (poll_exhausted) begin
                                        done  <= 1'b1;
                                        res_q <= RES_TIMEOUT;
                                        state <= S_IDLE;
                                    end else begin
                                        poll_cnt <= poll_cnt + 1'b1;
                                        state    <= S_GAP;
                                    end
                                end else begin
                                    done  <= 1'b1;
                                    res_q <= st_wel ? RES_WEL_STUCK : RES_OK;
                                    state <= S_IDLE;
                                end
                            end
                        endcase
                    end
                end
                S_GAP: begin
                    if (gap_over) begin
                        state <= S_XFER;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    prot_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && guard_hit) |=> busy ##1 (done && (result == 3'(RES_PROT))));

    // R9
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP && step == STEP_POLL) |-> (poll_cnt < poll_limit));
endmodule

// File: rtl/spi_blkerase_seq.sv
// Top of the SPI flash block-erase sequencer.
// Connects the sequencer, the mode-0 frame engine and the SCLK tick generator.
// Assumes: miso is synchronous to the SCLK produced here (host-side timing).
module spi_blkerase_seq #(
    parameter int ADDR_W     = 24,
    parameter int BLK_LSB    = 16,
    parameter int NUM_BLOCKS = 32,
    parameter int DIV_W      = 8,
    parameter int GAP_W      = 8,
    parameter int POLL_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sec_protect,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [GAP_W-1:0]  cs_gap,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              busy,
    output logic              done,
    output logic [2:0]        result,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int FRAME_W = 8 + ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic               xfer_start;
    logic               xfer_done;
    logic               xfer_active;
    logic               tick;
    logic [CNT_W-1:0]   xfer_nbits;
    logic [FRAME_W-1:0] xfer_tx;
    logic [7:0]         rx_byte;

    be_seq_ctrl #(
        .ADDR_W     (ADDR_W),
        .BLK_LSB    (BLK_LSB),
        .NUM_BLOCKS (NUM_BLOCKS),
        .GAP_W      (GAP_W),
        .POLL_W     (POLL_W),
        .FRAME_W    (FRAME_W),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .addr        (addr),
        .sec_protect (sec_protect),
        .cs_gap      (cs_gap),
        .poll_limit  (poll_limit),
        .xfer_done   (xfer_done),
        .rx_byte     (rx_byte),
        .xfer_start  (xfer_start),
        .xfer_nbits  (xfer_nbits),
        .xfer_tx     (xfer_tx),
        .busy        (busy),
        .done        (done),
        .result      (result)
    );

    be_sclk_tick #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (xfer_active),
        .div   (clk_div),
        .tick  (tick)
    );

    be_spi_shift #(
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (xfer_start),
        .nbits  (xfer_nbits),
        .tx     (xfer_tx),
        .tick   (tick),
        .miso   (miso),
        .active (xfer_active),
        .done   (xfer_done),
        .rx     (rx_byte),
        .sclk   (sclk),
        .cs_n   (cs_n),
        .mosi   (mosi)
    );
endmodule

// File: tb/test_spi_blkerase_seq.sv
// Bench: behavioural flash, frame queue and SCLK/CS timing monitor.
module test_spi_blkerase_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        sec = 1'b0;
    logic        miso = 1'b0;
    logic [23:0] addr = '0;
    logic [7:0]  div = 8'd1;
    logic [7:0]  gap = 8'd1;
    logic [15:0] plim = 16'd8;
    logic        busy, done, sclk, cs_n, mosi;
    logic [2:0]  result;

    always #4 clk = ~clk;

    spi_blkerase_seq i_spi_blkerase_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .sec_protect(sec),
        .clk_div(div), .cs_gap(gap), .poll_limit(plim), .busy(busy), .done(done),
        .result(result), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural flash ----------------
    bit          m_wel = 0, m_busy = 0, m_ign_wren = 0, m_stuck = 0, in_frame = 0;
    int          m_busy_reads = 0, m_busy_left = 0, m_erases = 0, m_frames = 0;
    logic [23:0] m_last_addr = '0;
    int          fbits = 0;
    logic [31:0] fsh = '0;
    logic [7:0]  fop = '0, fstat = '0;
    logic [39:0] expq[$];
    int          frame_err = 0;

    always @(negedge cs_n) begin
        in_frame = 1;
        fbits = 0;
        fsh = '0;
        fop = '0;
    end

    always @(posedge sclk) if (!cs_n) begin
        fsh = {fsh[30:0], mosi};
        fbits++;
        if (fbits == 8) begin
            fop = fsh[7:0];
            fstat = {6'b0, m_wel, m_busy};
        end
    end

    always @(negedge sclk) if (!cs_n && fop == 8'h05 && fbits >= 8 && fbits < 16)
        miso <= fstat[15-fbits];

    always @(posedge cs_n) if (in_frame) begin
        logic [39:0] obs, e;
        in_frame = 0;
        m_frames++;
        obs = {(fbits >= 8) ? fop : 8'h00, 8'(fbits), (fbits == 32) ? fsh[23:0] : 24'h0};
        if (expq.size() == 0) frame_err++;
        else begin
            e = expq.pop_front();
            if (e !== obs) frame_err++;
        end
        if (fop == 8'h06 && fbits == 8 && !m_ign_wren) m_wel = 1;
        else if (fop == 8'hD8 && fbits == 32 && m_wel && !m_busy) begin
            m_erases++;
            m_last_addr = fsh[23:0];
            m_busy = 1;
            m_busy_left = m_busy_reads;
            if (m_busy_left == 0) begin m_busy = 0; m_wel = m_stuck; end
        end else if (fop == 8'h05 && fbits == 16 && m_busy) begin
            if (m_busy_left > 0) m_busy_left--;
            if (m_busy_left == 0) begin m_busy = 0; m_wel = m_stuck; end
        end
    end

    // ---------------- timing monitor, every clock ----------------
    int cyc = 0, last_edge = 0, cs_rise_cyc = 0, hp_min = 0, hp_max = 0, gap_min = 0, viol = 0;
    bit p_cs = 1, p_sclk = 0, wd_fired = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cs_n === 1'b1 && sclk === 1'b1) viol++;
            if (p_cs && !cs_n) begin
                last_edge = cyc;
                if (cyc - cs_rise_cyc < gap_min) gap_min = cyc - cs_rise_cyc;
            end else if (!p_cs && cs_n) begin
                cs_rise_cyc = cyc;
            end else if (!cs_n && sclk != p_sclk) begin
                if (cyc - last_edge < hp_min) hp_min = cyc - last_edge;
                if (cyc - last_edge > hp_max) hp_max = cyc - last_edge;
                last_edge = cyc;
            end
        end
        p_cs = cs_n;
        p_sclk = sclk;
    end

    always @(posedge clk) if (cyc > 150000 && !wd_fired) begin
        wd_fired = 1;
        tests++;
        fails++;
        $display("FAIL R12 watchdog actual=%0d expected<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- one erase request ----------------
    task automatic run(input logic [23:0] a, input bit s, input logic [7:0] d, input logic [7:0] g,
                       input logic [15:0] lim, input int nbusy, input bit ign, input bit stuck,
                       input bit poke, input string tag);
        logic [7:0] blk;
        bit         prot;
        int         np, base_er;
        logic [2:0] exp_res;
        bit         seen;
        m_wel = 0; m_busy = 0; m_ign_wren = ign; m_stuck = stuck; m_busy_reads = nbusy;
        expq.delete();
        frame_err = 0; hp_min = 1000000; hp_max = 0; gap_min = 1000000;
        base_er = m_erases;
        blk = a[23:16];
        prot = s && (blk == 8'd0 || blk == 8'd31);
        if (prot) exp_res = 3'd1;
        else if (ign) exp_res = 3'd2;
        else if (nbusy >= int'(lim)) exp_res = 3'd3;
        else if (stuck) exp_res = 3'd4;
        else exp_res = 3'd0;
        if (!prot) begin
            expq.push_back({8'h06, 8'd8, 24'h0});
            expq.push_back({8'h05, 8'd16, 24'h0});
            if (!ign) begin
                expq.push_back({8'hD8, 8'd32, blk, 16'h0});
                np = (nbusy >= int'(lim)) ? int'(lim) : nbusy + 1;
                for (int k = 0; k < np; k++) expq.push_back({8'h05, 8'd16, 24'h0});
            end
        end
        @(negedge clk);
        addr = a; sec = s; div = d; gap = g; plim = lim; req = 1;
        @(negedge clk);
        req = 0;
        chk(busy == 1'b1, {tag, " R12 busy after req"}, busy, 1);
        seen = 0;
        for (int i = 0; i < 40000; i++) begin
            if (poke && i == 50) begin req = 1; addr = a ^ 24'h0A0000; end
            if (poke && i == 51) req = 0;
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        req = 0;
        chk(seen, {tag, " R12 done seen"}, seen, 1);
        chk(result == exp_res, {tag, " result code"}, result, exp_res);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R12 done one cycle"}, done, 0);
        chk(expq.size() == 0 && frame_err == 0, {tag, " R2 R4 frame sequence"}, frame_err + expq.size(), 0);
        chk(m_erases - base_er == ((prot || ign) ? 0 : 1), {tag, " R7 R11 erase count"},
            m_erases - base_er, (prot || ign) ? 0 : 1);
        if (!prot && !ign)
            chk(m_last_addr == {blk, 16'h0}, {tag, " R3 erase address"}, m_last_addr, {blk, 16'h0});
        if (!prot) begin
            chk(hp_min == int'(d) + 1 && hp_max == int'(d) + 1, {tag, " R5 half period"},
                hp_max, int'(d) + 1);
            chk(gap_min >= int'(g), {tag, " R6 cs gap"}, gap_min, g);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
        chk(mosi == 1'b0, "R1 mosi in reset", mosi, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", {busy, done}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1 && busy == 1'b0, "R1 idle after reset", {cs_n, busy}, 2);

        run(24'h05ABCD, 0, 8'd1, 8'd3, 16'd20, 3, 0, 0, 1, "R8 normal erase with poke");
        run(24'h1F1234, 0, 8'd0, 8'd1, 16'd20, 0, 0, 0, 0, "R11 top block unprotected");
        run(24'h1F0000, 1, 8'd1, 8'd2, 16'd20, 0, 0, 0, 0, "R11 top block protected");
        run(24'h00FFFF, 1, 8'd1, 8'd2, 16'd20, 0, 0, 0, 0, "R11 bottom block protected");
        run(24'h100000, 1, 8'd2, 8'd5, 16'd20, 2, 0, 0, 0, "R11 middle block protected set");
        run(24'h084000, 0, 8'd1, 8'd2, 16'd20, 0, 1, 0, 0, "R7 latch not set");
        run(24'h0C0000, 0, 8'd1, 8'd2, 16'd4, 10, 0, 0, 0, "R9 poll timeout");
        run(24'h020000, 0, 8'd3, 8'd7, 16'd20, 1, 0, 1, 0, "R10 latch stuck");
        chk(viol == 0, "R4 sclk low while cs_n high", viol, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule